// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block sits between a processor-side request port and an asynchronous DRAM device that has a shared row/column address bus and active-low strobes. A request carries an address, a write flag and write data. The controller splits the address into a row part (upper bits) and a column part (lower bits). It drives the row address, lowers the row strobe, then drives the column address and lowers the column strobe. For a read it captures the device data and returns it on a one-cycle response pulse. Every device timing limit is a nanosecond parameter. Each one is turned into a whole number of system clock cycles by rounding up.

After an access the row stays open. A following request to the same row is served with a column cycle alone. A request to a different row closes the row, waits out the precharge time, and opens the new row. Writes use the early form: write enable is low before the column strobe falls. A refresh input closes any open row and blocks new requests while it is high.

Top module: `pgdram_ctrl`

## Requirements
- R1: During and after reset, with no request, `ras_n`, `cas_n`, `we_n` and `oe_n` are all high, `rsp_valid` and `dq_oe` are low, and `req_ready` is high.
- R2: On `ma`, the row is `req_addr[ROW_W+COL_W-1:COL_W]` when `ras_n` falls and the column is `req_addr[COL_W-1:0]` when `cas_n` falls. A read returns the data last written to the same address.
- R3: Two falls of `ras_n` are at least ceil(T_RC_NS/CLK_NS) cycles apart.
- R4: `ras_n` stays high for at least ceil(T_RP_NS/CLK_NS) cycles before it falls again.
- R5: Read data is captured no sooner than ceil(T_CAC_NS/CLK_NS) cycles after the fall of `cas_n` and no sooner than ceil(T_RAC_NS/CLK_NS) cycles after the fall of `ras_n`. Responses come in request order, each as a single-cycle `rsp_valid` pulse.
- R6: Two falls of `cas_n` are at least ceil(T_PC_NS/CLK_NS) cycles apart.
- R7: A request to the row that is already open is served with no change on `ras_n`. Only `cas_n` toggles.
- R8: A request to a different row raises `ras_n` and then reopens with the new row.
- R9: For a write, `we_n` is low at least one cycle before `cas_n` falls and stays constant while `cas_n` is low. `oe_n` stays high and `dq_oe` is high during that write column cycle.
- R10: While `refresh_req` is high, `req_ready` is low and an open row is closed (`ras_n` high).
- R11: `cas_n` is low only while `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| refresh_req | input | 1 | Close open row and hold off requests |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ma | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | DATA_W | Data driven toward the device |
| dq_oe | output | 1 | Enable for `dq_out` |
| dq_in | input | DATA_W | Data returned by the device |

## Verification
Two events can land in the same cycle: a refresh request and a page-hit request. Either one could claim the open row. The bench raises `refresh_req` on the same clock as a valid request to the open row. It then checks that `req_ready` stays low for the whole refresh window and that `ras_n` goes high. After release, the request must be served with a fresh row opening (one more fall of `ras_n`) and must still return the correct data through the scoreboard.

// File: rtl/pgdram_pkg.sv
`timescale 1ns/1ps
package pgdram_pkg;

   typedef enum logic [2:0] {
      ST_CLOSED,
      ST_RAS,
      ST_RCD,
      ST_CSET,
      ST_CAS,
      ST_OPEN
   } ctl_st_e;

   // Nanoseconds to clock cycles, rounded up.
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/pgdram_gap_timer.sv
`timescale 1ns/1ps
module pgdram_gap_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/pgdram_row_track.sv
`timescale 1ns/1ps
module pgdram_row_track #(
   parameter int ROW_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             close,
   input  logic [ROW_W-1:0] row_in,
   input  logic [ROW_W-1:0] req_row,
   output logic             hit
);
   logic             open_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (close) begin
         open_q <= 1'b0;
      end else if (open_set) begin
         open_q <= 1'b1;
         row_q  <= row_in;
      end
   end

   assign hit = open_q && (row_q == req_row);
endmodule

// File: rtl/pgdram_ctrl.sv
`timescale 1ns/1ps
module pgdram_ctrl
   import pgdram_pkg::*;
#(
   parameter int ROW_W     = 9,
   parameter int COL_W     = 9,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 20,
   parameter int T_RC_NS   = 110,
   parameter int T_RAC_NS  = 60,
   parameter int T_CAC_NS  = 15,
   parameter int T_PC_NS   = 40,
   parameter int T_RP_NS   = 50
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic                   rsp_valid,
   output logic [DATA_W-1:0]      rsp_rdata,
   input  logic                   refresh_req,
   output logic                   ras_n,
   output logic                   cas_n,
   output logic                   we_n,
   output logic                   oe_n,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ma,
   output logic [DATA_W-1:0]      dq_out,
   output logic                   dq_oe,
   input  logic [DATA_W-1:0]      dq_in
);
   localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int RC_CY  = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int RP_CY  = ns_to_cyc(T_RP_NS, CLK_NS);
   localparam int PC_CY  = ns_to_cyc(T_PC_NS, CLK_NS);
   localparam int CAC_CY = ns_to_cyc(T_CAC_NS, CLK_NS);
   localparam int RCD_CY = ns_to_cyc(T_RAC_NS - T_CAC_NS, CLK_NS);
   localparam int MAX_A  = (RC_CY > RP_CY) ? RC_CY : RP_CY;
   localparam int MAX_B  = (PC_CY > CAC_CY) ? PC_CY : CAC_CY;
   localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_CY = (MAX_C > RCD_CY) ? MAX_C : RCD_CY;
   localparam int CNT_W  = $clog2(MAX_CY + 1);
   localparam int N_TMR  = 3;
   localparam int TI_RC  = 0;
   localparam int TI_RP  = 1;
   localparam int TI_PC  = 2;

   // Elaboration-time parameter checks
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pgdram_ctrl: widths must be positive");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("pgdram_ctrl: clock period must be positive");
   end
   if (T_RAC_NS <= T_CAC_NS || T_CAC_NS < 1) begin : g_bad_acc
      $error("pgdram_ctrl: row access time must exceed column access time");
   end
   if (T_RC_NS < 1 || T_PC_NS < 1 || T_RP_NS < 1) begin : g_bad_cyc
      $error("pgdram_ctrl: cycle and precharge times must be positive");
   end

   ctl_st_e              st;
   logic [CNT_W-1:0]     wcnt;
   logic [COL_W-1:0]     lat_col;
   logic                 lat_write;
   logic [DATA_W-1:0]    lat_wdata;
   logic [ROW_W-1:0]     req_row;
   logic [COL_W-1:0]     req_col;
   logic                 hit;
   logic                 accept;
   logic                 ev_ras_fall, ev_ras_rise, ev_cas_fall;
   logic [N_TMR-1:0]     tmr_start, tmr_done;
   logic [CNT_W-1:0]     tmr_val [N_TMR];

   assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
   assign req_col = req_addr[COL_W-1:0];

   assign req_ready = !refresh_req &&
                      ((st == ST_CLOSED) || (st == ST_OPEN && hit));
   assign accept    = req_valid && req_ready;

   assign ev_ras_fall = (st == ST_RAS) && tmr_done[TI_RC] && tmr_done[TI_RP];
   assign ev_ras_rise = (st == ST_OPEN) && (refresh_req || (req_valid && !hit));
   assign ev_cas_fall = (st == ST_CSET) && tmr_done[TI_PC];

   assign tmr_start[TI_RC] = ev_ras_fall;
   assign tmr_start[TI_RP] = ev_ras_rise;
   assign tmr_start[TI_PC] = ev_cas_fall;
   assign tmr_val[TI_RC]   = CNT_W'(RC_CY - 1);
   assign tmr_val[TI_RP]   = CNT_W'(RP_CY - 1);
   assign tmr_val[TI_PC]   = CNT_W'(PC_CY - 1);

   for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
      pgdram_gap_timer #(.W(CNT_W)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (tmr_start[g]),
         .val     (tmr_val[g]),
         .expired (tmr_done[g])
      );
   end

   pgdram_row_track #(.ROW_W(ROW_W)) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_set (accept && (st == ST_CLOSED)),
      .close    (ev_ras_rise),
      .row_in   (req_row),
      .req_row  (req_row),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_CLOSED;
         ras_n     <= 1'b1;
         cas_n     <= 1'b1;
         we_n      <= 1'b1;
         oe_n      <= 1'b1;
         ma        <= '0;
         dq_out    <= '0;
         dq_oe     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         wcnt      <= '0;
         lat_col   <= '0;
         lat_write <= 1'b0;
         lat_wdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (wcnt != '0) wcnt <= wcnt - 1'b1;
         unique case (st)
            ST_CLOSED: if (accept) begin
               ma        <= MA_W'(req_row);
               lat_col   <= req_col;
               lat_write <= req_write;
               lat_wdata <= req_wdata;
               st        <= ST_RAS;
            end
            ST_RAS: if (ev_ras_fall) begin
               ras_n <= 1'b0;
               wcnt  <= CNT_W'(RCD_CY - 1);
               st    <= ST_RCD;
            end
            ST_RCD: if (wcnt == '0) begin
               ma     <= MA_W'(lat_col);
               we_n   <= !lat_write;
               oe_n   <= lat_write;
               dq_oe  <= lat_write;
               dq_out <= lat_wdata;
               st     <= ST_CSET;
            end
            ST_CSET: if (ev_cas_fall) begin
               cas_n <= 1'b0;
               wcnt  <= CNT_W'(CAC_CY - 1);
               st    <= ST_CAS;
            end
            ST_CAS: if (wcnt == '0) begin
               cas_n <= 1'b1;
               we_n  <= 1'b1;
               oe_n  <= 1'b1;
               dq_oe <= 1'b0;
               if (!lat_write) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= dq_in;
               end
               st <= ST_OPEN;
            end
            ST_OPEN: begin
               if (ev_ras_rise) begin
                  ras_n <= 1'b1;
                  st    <= ST_CLOSED;
               end else if (accept) begin
                  ma        <= MA_W'(req_col);
                  we_n      <= !req_write;
                  oe_n      <= req_write;
                  dq_oe     <= req_write;
                  dq_out    <= req_wdata;
                  lat_write <= req_write;
                  st        <= ST_CSET;
               end
            end
            default: st <= ST_CLOSED;
         endcase
      end
   end
endmodule

// File: rtl/pgdram_chk.sv
`timescale 1ns/1ps
module pgdram_chk
   import pgdram_pkg::*;
#(
   parameter int CLK_NS   = 20,
   parameter int T_RC_NS  = 110,
   parameter int T_RAC_NS = 60,
   parameter int T_CAC_NS = 15,
   parameter int T_PC_NS  = 40,
   parameter int T_RP_NS  = 50
) (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic rsp_valid,
   input logic refresh_req,
   input logic req_ready
);
   localparam int RC_CY  = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int RP_CY  = ns_to_cyc(T_RP_NS, CLK_NS);
   localparam int PC_CY  = ns_to_cyc(T_PC_NS, CLK_NS);
   localparam int CAC_CY = ns_to_cyc(T_CAC_NS, CLK_NS);
   localparam int RAC_CY = ns_to_cyc(T_RAC_NS, CLK_NS);

   logic        ras_q, cas_q;
   logic [15:0] gap_rasf, gap_rasr, gap_casf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q    <= 1'b1;
         cas_q    <= 1'b1;
         gap_rasf <= 16'hFFFF;
         gap_rasr <= 16'hFFFF;
         gap_casf <= 16'hFFFF;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         if (ras_q && !ras_n)          gap_rasf <= 16'd1;
         else if (gap_rasf != 16'hFFFF) gap_rasf <= gap_rasf + 16'd1;
         if (!ras_q && ras_n)          gap_rasr <= 16'd1;
         else if (gap_rasr != 16'hFFFF) gap_rasr <= gap_rasr + 16'd1;
         if (cas_q && !cas_n)          gap_casf <= 16'd1;
         else if (gap_casf != 16'hFFFF) gap_casf <= gap_casf + 16'd1;
      end
   end

   a_r3_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> gap_rasf >= 16'(RC_CY));
   a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> gap_rasr >= 16'(RP_CY));
   a_r6_page_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> gap_casf >= 16'(PC_CY));
   a_r5_col_access: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> gap_casf >= 16'(CAC_CY));
   a_r5_row_access: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> gap_rasf >= 16'(RAC_CY));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r11_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);
   a_r9_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |-> $past(!we_n));
   a_r9_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && $past(!cas_n)) |-> $stable(we_n));
   a_r10_refresh_block: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> !req_ready);
endmodule

bind pgdram_ctrl pgdram_chk #(
   .CLK_NS   (CLK_NS),
   .T_RC_NS  (T_RC_NS),
   .T_RAC_NS (T_RAC_NS),
   .T_CAC_NS (T_CAC_NS),
   .T_PC_NS  (T_PC_NS),
   .T_RP_NS  (T_RP_NS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .rsp_valid   (rsp_valid),
   .refresh_req (refresh_req),
   .req_ready   (req_ready)
);

// File: tb/pgdram_ctrl_tb.sv
`timescale 1ns/1ps
module pgdram_ctrl_tb;
   localparam int ROW_W = 9;
   localparam int COL_W = 9;
   localparam int DW    = 8;
   localparam int MA_W  = 9;
   // Expected cycle minimums at 20 ns: ceil(110/20), ceil(50/20), ...
   localparam int RC_CY  = 6;
   localparam int RP_CY  = 3;
   localparam int PC_CY  = 2;
   localparam int CAC_CY = 1;
   localparam int RAC_CY = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
   logic [ROW_W+COL_W-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0, dq_in = '0;
   logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [DW-1:0] rsp_rdata, dq_out;
   logic [MA_W-1:0] ma;

   always #10 clk = ~clk;

   pgdram_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .refresh_req(refresh_req),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .ma(ma),
      .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
   );

   int checks = 0, errors = 0;
   logic [DW-1:0] dev_mem [int];
   logic [DW-1:0] ref_mem [int];
   logic [DW-1:0] exp_q [$];
   int ras_falls = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] dflt(input int key);
      return DW'(key) ^ 8'h5A;
   endfunction

   // Device model and timing monitor
   logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
   int since_rasf = 1000, since_rasr = 1000, since_casf = 1000;
   logic [ROW_W-1:0] row_l = '0;
   logic [COL_W-1:0] col_l = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         since_rasf++; since_rasr++; since_casf++;
         if (prev_ras && !ras_n) begin
            chk(since_rasf >= RC_CY, "R3 row cycle", since_rasf, RC_CY);
            chk(since_rasr >= RP_CY, "R4 precharge", since_rasr, RP_CY);
            row_l = ma[ROW_W-1:0];
            since_rasf = 0;
            ras_falls++;
         end
         if (!prev_ras && ras_n) since_rasr = 0;
         if (prev_cas && !cas_n) begin
            chk(!ras_n, "R11 cas in row", int'(ras_n), 0);
            chk(since_casf >= PC_CY, "R6 page cycle", since_casf, PC_CY);
            col_l = ma[COL_W-1:0];
            if (!we_n) begin
               chk(!prev_we, "R9 early write", int'(prev_we), 0);
               chk(oe_n && dq_oe, "R9 oe/dq during write", int'({oe_n, dq_oe}), 3);
               dev_mem[int'({row_l, col_l})] = dq_out;
            end
            since_casf = 0;
         end
         if (!cas_n && !prev_cas)
            chk(we_n == prev_we, "R9 we hold", int'(we_n), int'(prev_we));
         if (!cas_n && !oe_n)
            dq_in = dev_mem.exists(int'({row_l, col_l})) ?
                    dev_mem[int'({row_l, col_l})] : dflt(int'({row_l, col_l}));
         if (rsp_valid) begin
            chk(since_casf >= CAC_CY, "R5 column access", since_casf, CAC_CY);
            chk(since_rasf >= RAC_CY, "R5 row access", since_rasf, RAC_CY);
         end
      end
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
   end

   // Scoreboard monitor
   logic prev_rsp = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            chk(!prev_rsp, "R5 single pulse", 1, 0);
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", 1, 0);
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk(rsp_rdata == e, "R2 read data", int'(rsp_rdata), int'(e));
            end
         end
      end
      prev_rsp = rsp_valid;
   end

   // Driver: starts just after a falling edge
   task automatic send(input bit wr, input int row, input int col, input int data);
      int key;
      key = (row << COL_W) | col;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = (ROW_W+COL_W)'(key);
      req_wdata = DW'(data);
      #1;
      while (!req_ready) begin
         @(negedge clk); #1;
      end
      if (wr) ref_mem[key] = DW'(data);
      else exp_q.push_back(ref_mem.exists(key) ? ref_mem[key] : dflt(key));
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while (exp_q.size() != 0 && n < 200) begin
         @(negedge clk); n++;
      end
      repeat (4) @(negedge clk);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes idle", int'({ras_n, cas_n, we_n, oe_n}), 15);
      chk(!rsp_valid && !dq_oe, "R1 outputs low", int'({rsp_valid, dq_oe}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes after reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
      chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

      // R7: page hits keep the row open
      send(1, 5, 3, 8'h11);
      send(1, 5, 4, 8'h22);
      send(0, 5, 3, 0);
      send(0, 5, 4, 0);
      send(0, 5, 9, 0);
      drain();
      chk(ras_falls == 1, "R7 one row open for hits", ras_falls, 1);
      chk(!ras_n, "R7 row stays open", int'(ras_n), 0);

      // R8: misses close and reopen
      base = ras_falls;
      send(0, 9, 3, 0);
      send(0, 5, 3, 0);
      send(1, 300, 511, 8'hC3);
      send(0, 300, 511, 0);
      drain();
      chk(ras_falls == base + 3, "R8 reopen per miss", ras_falls, base + 3);

      // R10: refresh and a page hit in the same cycle
      base = ras_falls;
      fork
         send(0, 300, 511, 0);
         begin
            refresh_req = 1'b1;
            for (int i = 0; i < 6; i++) begin
               #1 chk(!req_ready, "R10 ready held low", int'(req_ready), 0);
               @(negedge clk);
            end
            chk(ras_n, "R10 row closed", int'(ras_n), 1);
            refresh_req = 1'b0;
         end
      join
      drain();
      chk(ras_falls == base + 1, "R10 row reopened after refresh", ras_falls, base + 1);

      // Mixed pattern: R2 address split across rows and columns
      for (int i = 0; i < 12; i++) send(1, i % 3 + 20, i * 7 % 512, 8'h40 + i);
      for (int i = 11; i >= 0; i--) send(0, i % 3 + 20, i * 7 % 512, 0);
      drain();
      chk(exp_q.size() == 0, "R5 all responses returned", exp_q.size(), 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule